// File: doc/BRIEF.md
# Dual-Setpoint Hysteresis Trip Comparator

This block decides whether a monitored quantity has crossed a protection limit. It holds a one-bit trip state and compares the incoming value against one of two thresholds. While the output is normal, the comparator sees the trip threshold. While the output is tripped, it sees the clear threshold. The gap between the two thresholds gives a bistable output with hysteresis, and a single magnitude comparator serves both thresholds.

A direction input selects the sense of the check. In rising mode the block trips on high values. In falling mode it trips on low values. The state moves only on a clock edge where the update strobe is high, so the surrounding sequencer chooses the point in its computation cycle at which the trip may change. Between strobes the output is a register that holds its value.

A typical use has two instances. One watches the raw converter sample and is strobed at the start of each cycle. The other watches the filtered value and is strobed at the end. The threshold registers and how they are loaded are outside this block.

Top module: `dual_sp_trip`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `trip` is 1 (tripped), the fail-safe state.
- R2: In rising mode (`low_mode`=0) with `trip`=0, an edge with `update`=1 and `sample` > `trip_lvl` sets `trip` to 1 from the next cycle.
- R3: In rising mode with `trip`=1, an edge with `update`=1 and `sample` < `clear_lvl` sets `trip` to 0 from the next cycle.
- R4: Hysteresis. A tripped output stays tripped for any value that does not pass the clear threshold, even if it lies between the two thresholds. A normal output stays normal for any value that does not pass the trip threshold.
- R5: A value equal to the active threshold never changes the state, in either mode.
- R6: In falling mode (`low_mode`=1) the checks are mirrored. From normal, `sample` < `trip_lvl` trips. From tripped, `sample` > `clear_lvl` clears. Each change appears in the cycle after the strobed edge.
- R7: On an edge with `update`=0, `trip` keeps its value, whatever `sample`, the thresholds or `low_mode` are.
- R8: Only the active threshold matters. In normal state `clear_lvl` has no effect, and in tripped state `trip_lvl` has no effect.
- R9: With `SIGNED_CMP`=1 (the default), `sample`, `trip_lvl` and `clear_lvl` are compared as two's-complement numbers of `WIDTH` bits (default 12). With `SIGNED_CMP`=0 they are compared as unsigned numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; forces the tripped state |
| sample | input | WIDTH | Monitored value |
| trip_lvl | input | WIDTH | Threshold checked while the output is normal |
| clear_lvl | input | WIDTH | Threshold checked while the output is tripped |
| low_mode | input | 1 | 0: trip on a high value; 1: trip on a low value |
| update | input | 1 | Strobe; the state may change only on an edge where it is 1 |
| trip | output | 1 | Registered trip state (1 = tripped) |

## Verification
The assertions assume that `update`, `low_mode`, `sample` and both thresholds hold known values that are settled before each rising edge. They also rely on the comparator flags reflecting the threshold that matches the current state. They do not assume that `clear_lvl` lies on the safe side of `trip_lvl`, so inverted or equal threshold pairs are legal. The bench changes every input only on the falling clock edge. Its directed phase places values on each threshold, one count either side of it, and in the band between the thresholds, using negative numbers in falling mode. Its random phase draws values and threshold pairs from a narrow window around one another, so that equality and crossings occur often.

// File: rtl/trip_cmp_pkg.sv
package trip_cmp_pkg;

   typedef enum logic {
      ST_NORMAL  = 1'b0,
      ST_TRIPPED = 1'b1
   } trip_state_t;

   typedef struct packed {
      logic gt;
      logic lt;
      logic eq;
   } cmp_flags_t;

endpackage

// File: rtl/trip_magcmp.sv
module trip_magcmp
   import trip_cmp_pkg::*;
#(
   parameter int WIDTH      = 12,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [WIDTH-1:0] a_val,
   input  logic [WIDTH-1:0] b_val,
   output cmp_flags_t       flags
);

   logic a_gt_b;
   logic a_lt_b;

   generate
      if (SIGNED_CMP) begin : g_signed
         assign a_gt_b = $signed(a_val) > $signed(b_val);
         assign a_lt_b = $signed(a_val) < $signed(b_val);
      end else begin : g_unsigned
         assign a_gt_b = a_val > b_val;
         assign a_lt_b = a_val < b_val;
      end
   endgenerate

   always_comb begin
      flags.gt = a_gt_b;
      flags.lt = a_lt_b;
      flags.eq = (a_val == b_val);
   end

endmodule

// File: rtl/trip_sp_sel.sv
module trip_sp_sel #(
   parameter int WIDTH = 12
) (
   input  logic             use_clear,
   input  logic [WIDTH-1:0] trip_lvl,
   input  logic [WIDTH-1:0] clear_lvl,
   output logic [WIDTH-1:0] active_lvl
);

   always_comb begin
      if (use_clear) active_lvl = clear_lvl;
      else           active_lvl = trip_lvl;
   end

endmodule

// File: rtl/trip_fsm.sv
module trip_fsm
   import trip_cmp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       update,
   input  logic       low_mode,
   input  cmp_flags_t flags,
   output logic       tripped
);

   trip_state_t st_q;
   trip_state_t st_d;
   logic        go_trip;
   logic        go_clear;

   always_comb begin
      go_trip  = low_mode ? flags.lt : flags.gt;
      go_clear = low_mode ? flags.gt : flags.lt;
      st_d     = st_q;
      if (update) begin
         case (st_q)
            ST_NORMAL:  if (go_trip)  st_d = ST_TRIPPED;
            ST_TRIPPED: if (go_clear) st_d = ST_NORMAL;
            default:    st_d = ST_TRIPPED;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_TRIPPED;
      else        st_q <= st_d;
   end

   assign tripped = (st_q == ST_TRIPPED);

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({flags.gt, flags.lt, flags.eq}) == 1); // R5
   AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !update |=> $stable(tripped)); // R7
   AST_EQ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (update && flags.eq) |=> $stable(tripped)); // R5
   AST_RISE_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      (update && !low_mode && !tripped && flags.gt) |=> tripped); // R2
   AST_RISE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (update && !low_mode && tripped && flags.lt) |=> !tripped); // R3
   AST_FALL_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      (update && low_mode && !tripped && flags.lt) |=> tripped); // R6
   AST_FALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (update && low_mode && tripped && flags.gt) |=> !tripped); // R6

endmodule

// File: rtl/dual_sp_trip.sv
module dual_sp_trip
   import trip_cmp_pkg::*;
#(
   parameter int WIDTH      = 12,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sample,
   input  logic [WIDTH-1:0] trip_lvl,
   input  logic [WIDTH-1:0] clear_lvl,
   input  logic             low_mode,
   input  logic             update,
   output logic             trip
);

   localparam int CMP_W = WIDTH;

   generate
      if (WIDTH < 2 || WIDTH > 64) begin : g_bad_width
         $error("dual_sp_trip: WIDTH must be 2..64");
      end
   endgenerate

   logic             tripped_q;
   logic [CMP_W-1:0] active_lvl;
   cmp_flags_t       flags;

   trip_sp_sel #(.WIDTH(CMP_W)) u_sel (
      .use_clear (tripped_q),
      .trip_lvl  (trip_lvl),
      .clear_lvl (clear_lvl),
      .active_lvl(active_lvl)
   );

   trip_magcmp #(.WIDTH(CMP_W), .SIGNED_CMP(SIGNED_CMP)) u_cmp (
      .a_val(sample),
      .b_val(active_lvl),
      .flags(flags)
   );

   trip_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .update  (update),
      .low_mode(low_mode),
      .flags   (flags),
      .tripped (tripped_q)
   );

   assign trip = tripped_q;

   AST_RESET_TRIPPED: assert property (@(posedge clk)
      !rst_n |=> trip); // R1

endmodule

// File: tb/dual_sp_trip_test.sv
module dual_sp_trip_test;

   localparam int W = 12;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] sample = '0;
   logic [W-1:0] trip_lvl = '0;
   logic [W-1:0] clear_lvl = '0;
   logic         low_mode = 1'b0;
   logic         update = 1'b0;
   logic         trip;

   int    checks = 0;
   int    failures = 0;
   string cur_req = "R1";
   bit    model_on = 1'b0;
   bit    exp_trip = 1'b1;

   always #4 clk = ~clk;

   dual_sp_trip #(.WIDTH(W), .SIGNED_CMP(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .sample(sample), .trip_lvl(trip_lvl),
      .clear_lvl(clear_lvl), .low_mode(low_mode), .update(update), .trip(trip)
   );

   // behavioural reference, two's-complement integers
   always @(posedge clk) begin
      int s, t, c;
      s = $signed(sample);
      t = $signed(trip_lvl);
      c = $signed(clear_lvl);
      if (!rst_n) exp_trip <= 1'b1;
      else if (update) begin
         if (!exp_trip) begin
            if (!low_mode && s > t) exp_trip <= 1'b1;
            if ( low_mode && s < t) exp_trip <= 1'b1;
         end else begin
            if (!low_mode && s < c) exp_trip <= 1'b0;
            if ( low_mode && s > c) exp_trip <= 1'b0;
         end
      end
   end

   always @(negedge clk) begin
      if (model_on) begin
         checks++;
         if (trip !== exp_trip) begin
            failures++;
            $display("FAIL %s model: trip=%0b expected=%0b", cur_req, trip, exp_trip);
         end
      end
   end

   task automatic check(input string req, input bit exp);
      checks++;
      if (trip !== exp) begin
         failures++;
         $display("FAIL %s: trip=%0b expected=%0b", req, trip, exp);
      end
   endtask

   task automatic step(input string req, input int v, input bit upd, input bit exp);
      @(negedge clk);
      cur_req = req;
      sample  = W'(v);
      update  = upd;
      @(negedge clk);
      update  = 1'b0;
      check(req, exp);
   endtask

   initial begin
      #400000;
      failures++;
      $display("FAIL watchdog: timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", 1'b1);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 1'b1);
      model_on = 1'b1;

      // rising mode: trip 1000, clear 900
      trip_lvl  = W'(1000);
      clear_lvl = W'(900);
      low_mode  = 1'b0;
      step("R4", 950, 1'b1, 1'b1);
      step("R5", 900, 1'b1, 1'b1);
      step("R3", 899, 1'b1, 1'b0);
      step("R8", 950, 1'b1, 1'b0);
      step("R5", 1000, 1'b1, 1'b0);
      step("R7", 1500, 1'b0, 1'b0);
      step("R2", 1001, 1'b1, 1'b1);
      step("R7", -500, 1'b0, 1'b1);
      step("R8", 1200, 1'b1, 1'b1);

      // falling mode with negative thresholds: trip -200, clear -100
      low_mode  = 1'b1;
      trip_lvl  = W'(-200);
      clear_lvl = W'(-100);
      step("R4", -150, 1'b1, 1'b1);
      step("R5", -100, 1'b1, 1'b1);
      step("R9", 50, 1'b1, 1'b0);
      step("R8", -150, 1'b1, 1'b0);
      step("R5", -200, 1'b1, 1'b0);
      step("R7", -300, 1'b0, 1'b0);
      step("R6", -201, 1'b1, 1'b1);
      step("R6", -99, 1'b1, 1'b0);

      // reset mid-run returns to tripped
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", 1'b1);
      rst_n = 1'b1;

      // random phase against the model
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         cur_req   = low_mode ? "R6" : "R2";
         sample    = W'(int'($urandom_range(0, 40)) - 20);
         update    = ($urandom_range(0, 3) != 0);
         if ($urandom_range(0, 15) == 0) low_mode = ~low_mode;
         if ($urandom_range(0, 31) == 0) begin
            trip_lvl  = W'(int'($urandom_range(0, 20)) - 10);
            clear_lvl = W'(int'($urandom_range(0, 20)) - 10);
         end
      end
      @(negedge clk);
      update = 1'b0;
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule